// File: doc/BRIEF.md
# Disk Task-File Device Model

This block models the device side of a parallel disk channel as seen from the host's port bus. The host reaches it through eight consecutive register offsets. Those offsets carry a 16-bit data port and a set of 8-bit registers: the sector count, three address bytes, the drive/head register, and one combined command/status offset. All task-file writes are latched. Only the drive whose select bit matches the `DEV_ID` parameter answers reads and accepts commands.

When a read-sectors command arrives, the model captures the count and the 28-bit logical block address. It then holds busy for a fixed latency. During that time an internal pattern generator fills a block-RAM sector buffer, and after it the model raises data request. The host then drains `WORDS` 16-bit words per sector from the data port. Between sectors the model goes busy again to refill the buffer, and data request drops after the last word of the last sector.

Identify returns a single sector holding a fixed pattern. Write-sectors accepts and discards the data. Any other command aborts with an error.

Top module: `tf_device`

## Requirements
- R1: After reset every task-file register reads 0x00, the error register reads 0x00, and the status reads 0x40 (bit 6 = ready, busy bit 7, data-request bit 3 and error bit 0 all clear).
- R2: Writes to offsets 2 (count), 3, 4, 5 (address bits 7:0, 15:8, 23:16) and 6 (drive/head) latch the low byte, which reads back at the same offset. Drive/head bits 3:0 are address bits 27:24.
- R3: The model responds only while drive/head bit 4 equals `DEV_ID`. Otherwise reads give `bus_rack` = 0 and `bus_rdata` = 0, and a command written to offset 7 is ignored.
- R4: A read (0x20), write (0x30) or identify (0xEC) command written to offset 7 makes the status read 0x80 for exactly L cycles after the write cycle, where L = max(`BUSY_LAT`, `WORDS`). The status then reads 0x48.
- R5: A read on offset 0 is acknowledged one cycle later. Word i of sector k of a read-sectors transfer equals ((start address + k) mod 2^16) XOR i.
- R6: Data request stays set until `WORDS` × count words have moved, with a count of 0 meaning 256 sectors. Each sector after the first is preceded by another L-cycle busy phase, and the status returns to 0x40 after the last word.
- R7: Identify transfers exactly one sector whose word i equals `IDENT_SEED` XOR i.
- R8: Write-sectors raises data request after the busy phase. Each write to offset 0 consumes one word, and data request clears after `WORDS` × count writes.
- R9: An unknown command code, or a read/write command issued while drive/head bit 6 (LBA mode) is 0, sets status bit 0 (status 0x41) and error-register bit 2 (0x04), with no busy and no data request. The next accepted command clears both.
- R10: A command written while busy or data request is set is ignored.
- R11: Task-file writes made after a command is accepted do not change the data of that transfer.
- R12: A read of offset 0 while no read transfer is requesting data returns 0 and does not advance the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset 0..7 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data (registers use bits 7:0) |
| bus_rdata | output | 16 | Read data, valid with `bus_rack` |
| bus_rack | output | 1 | Read answered by this drive, one cycle after `bus_rd` |

## Verification
The bench builds the block with `WORDS` = 16, `BUSY_LAT` = 20 and `DEV_ID` = 1. With 16-word sectors, multi-sector transfers and the count-of-zero case (256 sectors) complete in about ten thousand cycles. Because the latency exceeds the sector length, the busy window is governed by the latency parameter, and the window is checked cycle by cycle with back-to-back status reads. With `DEV_ID` = 1, the reset value of the drive/head register leaves the model deselected, which lets the bench exercise the silent-drive path before any setup.

// File: rtl/tf_pkg.sv
package tf_pkg;
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_XFER} seq_state_t;
  typedef enum logic [1:0] {OP_READ, OP_IDENT, OP_WRITE} op_kind_t;

  localparam logic [7:0] CMD_READ  = 8'h20;
  localparam logic [7:0] CMD_WRITE = 8'h30;
  localparam logic [7:0] CMD_IDENT = 8'hEC;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_ERR  = 3'd1;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_A0   = 3'd3;
  localparam logic [2:0] OFS_A1   = 3'd4;
  localparam logic [2:0] OFS_A2   = 3'd5;
  localparam logic [2:0] OFS_DEV  = 3'd6;
  localparam logic [2:0] OFS_CMD  = 3'd7;

  localparam int DEV_SEL_BIT = 4;
  localparam int DEV_LBA_BIT = 6;
  localparam int NREG        = 5;  // count, three address bytes, drive/head
endpackage

// File: rtl/tf_regs.sv
module tf_regs
  import tf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] file_q [NREG]
);
  // Offsets OFS_CNT .. OFS_DEV map to slots 0 .. NREG-1
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) file_q[i] <= 8'h00;
      else if (wr_en && addr == 3'(int'(OFS_CNT) + i)) file_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/tf_buf.sv
module tf_buf #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tf_seq.sv
module tf_seq
  import tf_pkg::*;
#(
  parameter int unsigned WORDS      = 256,
  parameter int unsigned BUSY_LAT   = 300,
  parameter logic [15:0] IDENT_SEED = 16'hC0DE,
  localparam int unsigned IW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_code,
  input  logic          data_rd_req,
  input  logic          data_wr_req,
  input  logic [7:0]    cnt,
  input  logic [27:0]   lba,
  input  logic          lba_mode,
  output logic          bsy,
  output logic          drq,
  output logic          err,
  output logic          abort,
  output logic          xfer_rd,
  output logic [IW-1:0] rd_idx,
  output logic          fill_we,
  output logic [IW-1:0] fill_addr,
  output logic [15:0]   fill_data
);
  localparam int unsigned LAT = (BUSY_LAT > WORDS) ? BUSY_LAT : WORDS;
  localparam int unsigned TW  = $clog2(LAT) + 1;
  localparam int unsigned SW  = 9;

  seq_state_t    state;
  op_kind_t      op;
  logic [TW-1:0] tmr;
  logic [IW-1:0] widx;
  logic [SW-1:0] left;
  logic [27:0]   cur_lba;
  logic          cmd_ok;
  op_kind_t      cmd_op;
  logic          adv;

  always_comb begin
    cmd_ok = 1'b0;
    cmd_op = OP_READ;
    case (cmd_code)
      CMD_READ:  begin cmd_ok = lba_mode; cmd_op = OP_READ;  end
      CMD_WRITE: begin cmd_ok = lba_mode; cmd_op = OP_WRITE; end
      CMD_IDENT: begin cmd_ok = 1'b1;     cmd_op = OP_IDENT; end
      default:   begin cmd_ok = 1'b0;     cmd_op = OP_READ;  end
    endcase
  end

  assign bsy     = (state == S_BUSY);
  assign drq     = (state == S_XFER);
  assign xfer_rd = drq && (op != OP_WRITE);
  assign rd_idx  = widx;
  assign adv     = drq && ((op == OP_WRITE) ? data_wr_req : data_rd_req);

  // Pattern generator writes one word per busy cycle until the sector is full
  assign fill_we   = bsy && (op != OP_WRITE) && (tmr < TW'(WORDS));
  assign fill_addr = tmr[IW-1:0];
  assign fill_data = ((op == OP_IDENT) ? IDENT_SEED : cur_lba[15:0]) ^ 16'(tmr[IW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      op      <= OP_READ;
      tmr     <= '0;
      widx    <= '0;
      left    <= '0;
      cur_lba <= '0;
      err     <= 1'b0;
      abort   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (cmd_wr) begin
            if (cmd_ok) begin
              op      <= cmd_op;
              cur_lba <= lba;
              tmr     <= '0;
              err     <= 1'b0;
              abort   <= 1'b0;
              state   <= S_BUSY;
              if (cmd_op == OP_IDENT) left <= SW'(1);
              else if (cnt == 8'd0)   left <= SW'(256);
              else                    left <= SW'(cnt);
            end else begin
              err   <= 1'b1;
              abort <= 1'b1;
            end
          end
        end
        S_BUSY: begin
          if (tmr == TW'(LAT - 1)) begin
            state <= S_XFER;
            widx  <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_XFER: begin
          if (adv) begin
            if (widx == IW'(WORDS - 1)) begin
              if (left == SW'(1)) begin
                state <= S_IDLE;
                left  <= '0;
              end else begin
                left    <= left - 1'b1;
                cur_lba <= cur_lba + 1'b1;
                tmr     <= '0;
                state   <= S_BUSY;
              end
            end else begin
              widx <= widx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tf_device.sv
module tf_device
  import tf_pkg::*;
#(
  parameter int unsigned WORDS      = 256,
  parameter int unsigned BUSY_LAT   = 300,
  parameter bit          DEV_ID     = 1'b0,
  parameter logic [15:0] IDENT_SEED = 16'hC0DE
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_rack
);
  localparam int unsigned IW = $clog2(WORDS);

  logic [7:0]    file_q [NREG];
  logic [7:0]    dev_q;
  logic          dev_sel;
  logic          rd_hit, wr_hit;
  logic          bsy, drq, err_f, abort_f, xfer_rd;
  logic [IW-1:0] rd_idx, fill_addr;
  logic          fill_we;
  logic [15:0]   fill_data, buf_q;
  logic [7:0]    status, reg_mux, reg_q;
  logic          data_sel_q, data_ok_q;
  logic          unused_wdata_hi;

  // Write data on the data port is accepted but discarded
  assign unused_wdata_hi = ^bus_wdata[15:8];

  assign dev_q   = file_q[NREG-1];
  assign dev_sel = (dev_q[DEV_SEL_BIT] == DEV_ID);
  assign rd_hit  = bus_rd && dev_sel;
  assign wr_hit  = bus_wr && dev_sel;

  tf_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata[7:0]),
    .file_q (file_q)
  );

  tf_seq #(
    .WORDS      (WORDS),
    .BUSY_LAT   (BUSY_LAT),
    .IDENT_SEED (IDENT_SEED)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (wr_hit && bus_addr == OFS_CMD),
    .cmd_code    (bus_wdata[7:0]),
    .data_rd_req (rd_hit && bus_addr == OFS_DATA),
    .data_wr_req (wr_hit && bus_addr == OFS_DATA),
    .cnt         (file_q[0]),
    .lba         ({dev_q[3:0], file_q[3], file_q[2], file_q[1]}),
    .lba_mode    (dev_q[DEV_LBA_BIT]),
    .bsy         (bsy),
    .drq         (drq),
    .err         (err_f),
    .abort       (abort_f),
    .xfer_rd     (xfer_rd),
    .rd_idx      (rd_idx),
    .fill_we     (fill_we),
    .fill_addr   (fill_addr),
    .fill_data   (fill_data)
  );

  tf_buf #(.DEPTH(WORDS), .AW(IW)) u_buf (
    .clk   (clk),
    .we    (fill_we),
    .waddr (fill_addr),
    .wdata (fill_data),
    .raddr (rd_idx),
    .rdata (buf_q)
  );

  assign status = {bsy, ~bsy, 2'b00, drq, 2'b00, err_f};

  always_comb begin
    case (bus_addr)
      OFS_ERR: reg_mux = {5'b00000, abort_f, 2'b00};
      OFS_CNT: reg_mux = file_q[0];
      OFS_A0:  reg_mux = file_q[1];
      OFS_A1:  reg_mux = file_q[2];
      OFS_A2:  reg_mux = file_q[3];
      OFS_DEV: reg_mux = dev_q;
      OFS_CMD: reg_mux = status;
      default: reg_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rack   <= 1'b0;
      data_sel_q <= 1'b0;
      data_ok_q  <= 1'b0;
      reg_q      <= 8'h00;
    end else begin
      bus_rack   <= rd_hit;
      data_sel_q <= (bus_addr == OFS_DATA);
      data_ok_q  <= rd_hit && (bus_addr == OFS_DATA) && xfer_rd;
      reg_q      <= reg_mux;
    end
  end

  always_comb begin
    if (!bus_rack)       bus_rdata = 16'h0000;
    else if (data_sel_q) bus_rdata = data_ok_q ? buf_q : 16'h0000;
    else                 bus_rdata = {8'h00, reg_q};
  end
endmodule

// File: rtl/tf_device_chk.sv
module tf_device_chk #(
  parameter int unsigned WORDS    = 256,
  parameter int unsigned BUSY_LAT = 300
) (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  cmd_byte,
  input logic [15:0] bus_rdata,
  input logic        bus_rack,
  input logic        bsy,
  input logic        drq,
  input logic        err,
  input logic        sel
);
  localparam int unsigned LAT = (BUSY_LAT > WORDS) ? BUSY_LAT : WORDS;

  logic [31:0] bsy_run;
  logic        bad_cmd;

  always_ff @(posedge clk) begin
    if (rst)      bsy_run <= '0;
    else if (bsy) bsy_run <= bsy_run + 1'b1;
    else          bsy_run <= '0;
  end

  assign bad_cmd = bus_wr && sel && bus_addr == 3'd7 && !bsy && !drq &&
                   cmd_byte != 8'h20 && cmd_byte != 8'h30 && cmd_byte != 8'hEC;

  // R4
  bsy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bsy) |-> bsy_run == LAT);

  // R6
  drq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bsy) |-> drq);

  // R3
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel) |=> (!bus_rack && bus_rdata == 16'h0000));

  // R3
  ack_source_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rack |-> $past(bus_rd && sel));

  // R9
  abort_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |=> (err && !bsy && !drq));

  // R10
  cmd_in_drq_chk: assert property (@(posedge clk) disable iff (rst)
    (drq && bus_wr && bus_addr == 3'd7) |=> drq);
endmodule

bind tf_device tf_device_chk #(.WORDS(WORDS), .BUSY_LAT(BUSY_LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .cmd_byte  (bus_wdata[7:0]),
  .bus_rdata (bus_rdata),
  .bus_rack  (bus_rack),
  .bsy       (bsy),
  .drq       (drq),
  .err       (err_f),
  .sel       (dev_sel)
);

// File: tb/tf_device_tb.sv
module tf_device_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 16;
  localparam int BUSY_LAT   = 20;
  localparam int L          = (BUSY_LAT > WORDS) ? BUSY_LAT : WORDS;
  localparam logic [15:0] SEED = 16'hC0DE;

  localparam logic [15:0] ST_IDLE = 16'h0040;
  localparam logic [15:0] ST_BUSY = 16'h0080;
  localparam logic [15:0] ST_DRQ  = 16'h0048;
  localparam logic [15:0] ST_ERR  = 16'h0041;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_rack;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic was_rd = 1'b0;

  logic [16:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tf_device #(
    .WORDS(WORDS), .BUSY_LAT(BUSY_LAT), .DEV_ID(1'b1), .IDENT_SEED(SEED)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rack(bus_rack)
  );

  // Monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) was_rd <= bus_rd;

  always @(negedge clk) begin
    if (was_rd && exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rack !== e[16] || bus_rdata !== e[15:0]) begin
        errors++;
        $display("FAIL %s: ack=%0b data=%04h expected ack=%0b data=%04h",
                 t, bus_rack, bus_rdata, e[16], e[15:0]);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic ack, input logic [15:0] d, input string t);
    exp_q.push_back({ack, d});
    tag_q.push_back(t);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state; drive/head resets to 0 so the drive with DEV_ID=1 is silent
    rd(3'd7, 1'b0, 16'h0000, "R3 deselected after reset");
    wr(3'd6, 16'h0050);
    rd(3'd7, 1'b1, ST_IDLE, "R1 reset status");
    rd(3'd1, 1'b1, 16'h0000, "R1 reset error");
    rd(3'd2, 1'b1, 16'h0000, "R1 reset count");
    rd(3'd3, 1'b1, 16'h0000, "R1 reset address low");

    // R2 task-file readback
    wr(3'd2, 16'hAA02); wr(3'd3, 16'h0034); wr(3'd4, 16'h0012);
    wr(3'd5, 16'h0056); wr(3'd6, 16'h0057);
    rd(3'd2, 1'b1, 16'h0002, "R2 count");
    rd(3'd3, 1'b1, 16'h0034, "R2 addr 7:0");
    rd(3'd4, 1'b1, 16'h0012, "R2 addr 15:8");
    rd(3'd5, 1'b1, 16'h0056, "R2 addr 23:16");
    rd(3'd6, 1'b1, 16'h0057, "R2 drive/head");

    // R3 deselected drive ignores reads and commands
    wr(3'd6, 16'h0047);
    rd(3'd7, 1'b0, 16'h0000, "R3 deselected status");
    rd(3'd2, 1'b0, 16'h0000, "R3 deselected count");
    wr(3'd7, 16'h0020);
    wr(3'd6, 16'h0057);
    rd(3'd7, 1'b1, ST_IDLE, "R3 command ignored while deselected");

    // R4 R5 R6 R10 R11: two-sector read
    wr(3'd7, 16'h0020);
    for (int c = 0; c < L; c++) rd(3'd7, 1'b1, ST_BUSY, "R4 busy window");
    rd(3'd7, 1'b1, ST_DRQ, "R4 data request after busy");
    for (int i = 0; i < 8; i++) rd(3'd0, 1'b1, 16'h1234 ^ 16'(i), "R5 sector 0 word");
    wr(3'd3, 16'h00FF);
    wr(3'd7, 16'h0099);
    rd(3'd7, 1'b1, ST_DRQ, "R10 command during transfer ignored");
    rd(3'd1, 1'b1, 16'h0000, "R10 no abort during transfer");
    for (int i = 8; i < WORDS; i++) rd(3'd0, 1'b1, 16'h1234 ^ 16'(i), "R5 sector 0 word");
    for (int c = 0; c < L; c++) rd(3'd7, 1'b1, ST_BUSY, "R6 busy between sectors");
    rd(3'd7, 1'b1, ST_DRQ, "R6 data request second sector");
    for (int i = 0; i < WORDS; i++) rd(3'd0, 1'b1, 16'h1235 ^ 16'(i), "R11 sector 1 word");
    rd(3'd7, 1'b1, ST_IDLE, "R6 data request dropped after last word");
    rd(3'd0, 1'b1, 16'h0000, "R12 data read while idle");
    rd(3'd7, 1'b1, ST_IDLE, "R12 idle read did not start transfer");

    // R7 identify
    wr(3'd7, 16'h00EC);
    idle(L);
    rd(3'd7, 1'b1, ST_DRQ, "R7 identify data request");
    for (int i = 0; i < WORDS; i++) rd(3'd0, 1'b1, SEED ^ 16'(i), "R7 identify word");
    rd(3'd7, 1'b1, ST_IDLE, "R7 identify single sector");

    // R8 write sectors
    wr(3'd2, 16'h0001);
    wr(3'd7, 16'h0030);
    idle(L);
    rd(3'd7, 1'b1, ST_DRQ, "R8 write data request");
    rd(3'd0, 1'b1, 16'h0000, "R12 data read during write transfer");
    for (int i = 0; i < WORDS - 1; i++) wr(3'd0, 16'hBE00 + 16'(i));
    rd(3'd7, 1'b1, ST_DRQ, "R8 data request before last write");
    wr(3'd0, 16'hBEFF);
    rd(3'd7, 1'b1, ST_IDLE, "R8 data request dropped after last write");

    // R9 abort paths
    wr(3'd7, 16'h0055);
    rd(3'd7, 1'b1, ST_ERR, "R9 unknown command status");
    rd(3'd1, 1'b1, 16'h0004, "R9 unknown command abort bit");
    wr(3'd6, 16'h0017);
    wr(3'd7, 16'h0020);
    rd(3'd7, 1'b1, ST_ERR, "R9 read without LBA mode rejected");
    wr(3'd7, 16'h00EC);
    rd(3'd7, 1'b1, ST_BUSY, "R9 accepted command clears error");
    rd(3'd1, 1'b1, 16'h0000, "R9 abort bit cleared");
    idle(L - 2);
    rd(3'd7, 1'b1, ST_DRQ, "R7 identify after error");
    for (int i = 0; i < WORDS; i++) rd(3'd0, 1'b1, SEED ^ 16'(i), "R7 identify word");

    // R6 count of zero means 256 sectors
    wr(3'd6, 16'h0057); wr(3'd2, 16'h0000); wr(3'd3, 16'h0000); wr(3'd4, 16'h0000);
    wr(3'd7, 16'h0020);
    for (int k = 0; k < 256; k++) begin
      idle(L);
      for (int i = 0; i < WORDS; i++) rd(3'd0, 1'b1, 16'(k) ^ 16'(i), "R6 count zero word");
    end
    rd(3'd7, 1'b1, ST_IDLE, "R6 count zero finished after 256 sectors");

    idle(3);
    done = 1'b1;
    summary();
  end
endmodule